// File: doc/BRIEF.md
# Two-Cycle Unsigned Byte Multiplier with Register File

This block executes an unsigned 8-bit by 8-bit multiply against a local file of 32 byte-wide registers and an 8-bit status register. Each instruction word it accepts is decoded. A multiply word names two source registers, and both are read as unsigned values. The 16-bit product always goes to the fixed pair made of register 0 (low byte) and register 1 (high byte). The carry and zero flags are updated from the product, and the other status bits are kept.

Execution takes two clock cycles. The operands are captured in the accepting cycle, and the write-back happens at the end of the following cycle. During that second cycle `busy` is high, and a one-cycle `done` pulse appears when the new register and flag values become visible. A word that is not a multiply passes through the same two-cycle sequence and changes nothing. A preload port lets a test environment write any register or the status byte. An observation port reads any register.

Top module: `mulx_unit`

## Requirements
- R1: A word whose bits [15:10] equal 100111 is a multiply. Its first operand register is bits [8:4] and its second is bit 9 joined above bits [3:0], so any of the 32 registers can be either operand.
- R2: The unsigned product of the two operands is written with its low byte in register 0 and its high byte in register 1.
- R3: Status bit 0 (carry) takes bit 15 of the product.
- R4: Status bit 1 (zero) is set exactly when the whole product is zero. A multiply leaves status bits 7:2 unchanged, and the status byte holds whenever no multiply finishes and no status preload occurs.
- R5: A word is accepted at a rising edge where `instr_valid` is high and `busy` is low. `busy` is then high for exactly the next cycle, and words presented while `busy` is high are ignored.
- R6: `done` is high for one cycle, starting at the same edge where registers 0 and 1 and the status byte take their new values, which is two edges after acceptance.
- R7: Operands are sampled at acceptance, so the result is correct when either operand is register 0 or register 1, and when both operands name the same register.
- R8: A non-multiply word changes no register and no status bit, yet still raises `done` with the same two-cycle timing.
- R9: A preload writes its register or the status byte at the next edge. When it falls on the write-back edge, the write-back wins for registers 0 and 1 and for status bits 1:0, and the preload still lands in every other register and in status bits 7:2.
- R10: After reset all registers and the status byte read zero, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 16 | Instruction word |
| busy | output | 1 | Second execution cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Register preload enable |
| ld_addr | input | 5 | Register preload index |
| ld_data | input | 8 | Register preload value |
| st_ld_en | input | 1 | Status preload enable |
| st_ld_data | input | 8 | Status preload value |
| obs_addr | input | 5 | Observation read index |
| obs_data | output | 8 | Observed register value |
| status | output | 8 | Status byte (bit 0 carry, bit 1 zero) |

## Verification
Two things can land on the same edge. One is the multiply write-back, which ends the busy cycle. The other is a preload from the test port, either to a register or to the status byte. The bench provokes this by driving preloads to register 0, to an unrelated register and to the status byte during the busy cycle. It then checks that registers 0 and 1 and status bits 1:0 carry the product, and that the unrelated register and status bits 7:2 carry the preload. A preload in the accepting cycle is also judged, by checking that the operand value sampled is the one from before the preload.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
    localparam int unsigned WORD_W   = 16;
    localparam logic [5:0]  MUL_OPC  = 6'b100111;
    localparam int unsigned C_BIT    = 0;
    localparam int unsigned Z_BIT    = 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } mulx_state_e;
endpackage

// File: rtl/mulx_decode.sv
module mulx_decode
    import mulx_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_mul,
    output logic [AW-1:0]     rd_idx,
    output logic [AW-1:0]     rr_idx
);
    always_comb begin
        is_mul = (word[15:10] == MUL_OPC);
        rd_idx = word[8:4];
        rr_idx = {word[9], word[3:0]};
    end
endmodule

// File: rtl/mulx_regfile.sv
module mulx_regfile #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned DW    = 8,
    parameter int unsigned AW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          pair_we,
    input  logic [DW-1:0] pair_lo,
    input  logic [DW-1:0] pair_hi,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    input  logic [AW-1:0] obs_addr,
    output logic [DW-1:0] obs_data
);
    logic [DW-1:0] regs_d [NREGS];
    logic [DW-1:0] regs_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (ld_en) begin
            regs_d[ld_addr] = ld_data;
        end
        if (pair_we) begin
            regs_d[0] = pair_lo;
            regs_d[1] = pair_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign ra_data  = regs_q[ra_addr];
    assign rb_data  = regs_q[rb_addr];
    assign obs_data = regs_q[obs_addr];

    // write-back takes priority over a colliding preload (R9)
    assert_pair_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pair_we |=> (regs_q[0] == $past(pair_lo)) && (regs_q[1] == $past(pair_hi)));

    assert_preload_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !(pair_we && ld_addr < 2)) |=> (regs_q[$past(ld_addr)] == $past(ld_data)));
endmodule

// File: rtl/mulx_ctrl.sv
module mulx_ctrl
    import mulx_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_mul,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          st_ld_en,
    input  logic [SW-1:0] st_ld_data,
    output logic          busy,
    output logic          done,
    output logic          pair_we,
    output logic [DW-1:0] pair_lo,
    output logic [DW-1:0] pair_hi,
    output logic [SW-1:0] status
);
    localparam int unsigned PW = 2 * DW;

    typedef struct packed {
        mulx_state_e   st;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          mul;
        logic          done;
        logic [SW-1:0] status;
    } ctrl_t;

    ctrl_t         q, d;
    logic [PW-1:0] prod;

    always_comb begin
        prod    = {{DW{1'b0}}, q.a} * {{DW{1'b0}}, q.b};
        busy    = (q.st == ST_EXEC);
        pair_we = busy && q.mul;
        pair_lo = prod[DW-1:0];
        pair_hi = prod[PW-1:DW];
        done    = q.done;
        status  = q.status;

        d      = q;
        d.done = busy;
        if (st_ld_en) begin
            d.status = st_ld_data;
        end
        if (pair_we) begin
            d.status[C_BIT] = prod[PW-1];
            d.status[Z_BIT] = (prod == '0);
        end
        if (busy) begin
            d.st  = ST_IDLE;
            d.mul = 1'b0;
        end else if (start) begin
            d.st  = ST_EXEC;
            d.a   = opa;
            d.b   = opb;
            d.mul = is_mul;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, a: '0, b: '0, mul: 1'b0, done: 1'b0, status: '0};
        end else begin
            q <= d;
        end
    end

    assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    assert_busy_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_status_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !st_ld_en) |=> $stable(status));

    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pair_we |=> (status[Z_BIT] == ($past(pair_lo) == '0 && $past(pair_hi) == '0)));
endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
    import mulx_pkg::*;
#(
    parameter int unsigned NREGS = 32,
    parameter int unsigned DW    = 8,
    parameter int unsigned SW    = 8,
    parameter int unsigned AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    output logic              busy,
    output logic              done,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_addr,
    input  logic [DW-1:0]     ld_data,
    input  logic              st_ld_en,
    input  logic [SW-1:0]     st_ld_data,
    input  logic [AW-1:0]     obs_addr,
    output logic [DW-1:0]     obs_data,
    output logic [SW-1:0]     status
);
    logic          is_mul;
    logic [AW-1:0] rd_idx, rr_idx;
    logic [DW-1:0] rd_val, rr_val;
    logic          start;
    logic          pair_we;
    logic [DW-1:0] pair_lo, pair_hi;

    mulx_decode #(.AW(AW)) u_dec (
        .word   (instr_word),
        .is_mul (is_mul),
        .rd_idx (rd_idx),
        .rr_idx (rr_idx)
    );

    mulx_regfile #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .pair_we  (pair_we),
        .pair_lo  (pair_lo),
        .pair_hi  (pair_hi),
        .ra_addr  (rd_idx),
        .ra_data  (rd_val),
        .rb_addr  (rr_idx),
        .rb_data  (rr_val),
        .obs_addr (obs_addr),
        .obs_data (obs_data)
    );

    assign start = instr_valid && !busy;

    mulx_ctrl #(.DW(DW), .SW(SW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .is_mul     (is_mul),
        .opa        (rd_val),
        .opb        (rr_val),
        .st_ld_en   (st_ld_en),
        .st_ld_data (st_ld_data),
        .busy       (busy),
        .done       (done),
        .pair_we    (pair_we),
        .pair_lo    (pair_lo),
        .pair_hi    (pair_hi),
        .status     (status)
    );

    assert_nonmul_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !is_mul) |=> !pair_we);
endmodule

// File: tb/mulx_unit_bench.sv
module mulx_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        busy, done;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        st_ld_en = 1'b0;
    logic [7:0]  st_ld_data = '0;
    logic [4:0]  obs_addr = '0;
    logic [7:0]  obs_data;
    logic [7:0]  status;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mulx_unit u_mulx_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .busy(busy), .done(done), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .st_ld_en(st_ld_en), .st_ld_data(st_ld_data), .obs_addr(obs_addr),
        .obs_data(obs_data), .status(status)
    );

    // rd(5) rr(5) a(8) b(8)
    localparam int NV = 8;
    localparam logic [25:0] VEC [NV] = '{
        {5'd16, 5'd17, 8'h0C, 8'h0A},
        {5'd2,  5'd3,  8'hFF, 8'hFF},
        {5'd4,  5'd5,  8'h00, 8'h37},
        {5'd0,  5'd1,  8'h80, 8'h02},
        {5'd1,  5'd0,  8'h10, 8'h10},
        {5'd31, 5'd31, 8'h90, 8'h90},
        {5'd30, 5'd16, 8'h81, 8'hFF},
        {5'd0,  5'd0,  8'h0F, 8'h0F}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mul_word(input logic [4:0] rd, input logic [4:0] rr);
        return {6'b100111, rr[4], rd, rr[3:0]};
    endfunction

    task automatic preload(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic read_reg(input logic [4:0] a, output logic [7:0] v);
        obs_addr = a;
        #1;
        v = obs_data;
    endtask

    // present word for one edge; returns at the negedge after write-back
    task automatic issue(input logic [15:0] w, input string req);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0;
        chk({req, " busy in second cycle"}, 16'(busy), 16'd1);
        chk({req, " no done yet"}, 16'(done), 16'd0);
        @(negedge clk);
        chk({req, " done pulse"}, 16'(done), 16'd1);
        chk({req, " busy cleared"}, 16'(busy), 16'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] lo, hi, t;
        logic [15:0] p;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", 16'(busy), 16'd0);
        chk("R10 done", 16'(done), 16'd0);
        chk("R10 status", 16'(status), 16'd0);
        read_reg(5'd7, t);  chk("R10 reg7", 16'(t), 16'd0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R7: vector table
        for (int i = 0; i < NV; i++) begin
            logic [4:0] rd, rr;
            logic [7:0] a, b;
            {rd, rr, a, b} = VEC[i];
            preload(rd, a);
            preload(rr, b);
            if (rd == rr) b = a;
            p = a * b;
            issue(mul_word(rd, rr), "R5 R6 vector");
            read_reg(5'd0, lo); read_reg(5'd1, hi);
            chk("R2 R7 product", {hi, lo}, p);
            chk("R3 carry", 16'(status[0]), 16'(p[15]));
            chk("R4 zero", 16'(status[1]), 16'(p == 0));
            chk("R4 upper status kept", 16'(status[7:2]), 16'd0);
        end

        // R4 upper bits kept across a multiply
        @(negedge clk); st_ld_en = 1'b1; st_ld_data = 8'hFC;
        @(negedge clk); st_ld_en = 1'b0;
        preload(5'd8, 8'h03); preload(5'd9, 8'h05);
        issue(mul_word(5'd8, 5'd9), "R4");
        chk("R4 status after mul", 16'(status), 16'h00FC);
        repeat (3) @(negedge clk);
        chk("R4 status holds when idle", 16'(status), 16'h00FC);

        // R8 non-multiply word
        preload(5'd0, 8'h11); preload(5'd1, 8'h22);
        issue(16'h0000, "R8");
        read_reg(5'd0, lo); read_reg(5'd1, hi);
        chk("R8 pair unchanged", {hi, lo}, 16'h2211);
        chk("R8 status unchanged", 16'(status), 16'h00FC);
        issue(16'h9800, "R8 near opcode");
        read_reg(5'd0, lo);
        chk("R8 near opcode R0", 16'(lo), 16'h0011);

        // R5 word during busy is ignored
        preload(5'd10, 8'h02); preload(5'd11, 8'h03);
        preload(5'd12, 8'h07); preload(5'd13, 8'h09);
        @(negedge clk); instr_valid = 1'b1; instr_word = mul_word(5'd10, 5'd11);
        @(negedge clk); instr_word = mul_word(5'd12, 5'd13);
        @(negedge clk); instr_valid = 1'b0;
        chk("R5 R6 done after first", 16'(done), 16'd1);
        @(negedge clk);
        chk("R5 no second done", 16'(done), 16'd0);
        chk("R5 no second busy", 16'(busy), 16'd0);
        read_reg(5'd0, lo); read_reg(5'd1, hi);
        chk("R5 ignored word no effect", {hi, lo}, 16'h0006);

        // R7 preload in accepting cycle: old operand used
        preload(5'd14, 8'h04); preload(5'd15, 8'h05);
        @(negedge clk); instr_valid = 1'b1; instr_word = mul_word(5'd14, 5'd15);
        ld_en = 1'b1; ld_addr = 5'd14; ld_data = 8'h09;
        @(negedge clk); instr_valid = 1'b0; ld_en = 1'b0;
        @(negedge clk);
        read_reg(5'd0, lo);
        chk("R7 sampled at accept", 16'(lo), 16'h0014);

        // R9 collision on write-back edge
        preload(5'd20, 8'h00); preload(5'd21, 8'h45);
        @(negedge clk); instr_valid = 1'b1; instr_word = mul_word(5'd20, 5'd21);
        @(negedge clk); instr_valid = 1'b0;
        ld_en = 1'b1; ld_addr = 5'd0; ld_data = 8'h55;
        st_ld_en = 1'b1; st_ld_data = 8'hFF;
        @(negedge clk); ld_en = 1'b0; st_ld_en = 1'b0;
        chk("R9 R6 done", 16'(done), 16'd1);
        read_reg(5'd0, lo);
        chk("R9 write-back beats preload", 16'(lo), 16'h0000);
        chk("R9 status merge", 16'(status), 16'h00FE);
        preload(5'd22, 8'h01); preload(5'd23, 8'h01);
        @(negedge clk); instr_valid = 1'b1; instr_word = mul_word(5'd22, 5'd23);
        @(negedge clk); instr_valid = 1'b0;
        ld_en = 1'b1; ld_addr = 5'd5; ld_data = 8'h66;
        @(negedge clk); ld_en = 1'b0;
        read_reg(5'd5, t);
        chk("R9 other preload lands", 16'(t), 16'h0066);
        read_reg(5'd0, lo);
        chk("R9 R2 product alongside", 16'(lo), 16'h0001);

        // R10 reset again clears
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        read_reg(5'd5, t);
        chk("R10 reset clears regs", 16'(t), 16'd0);
        chk("R10 reset clears status", 16'(status), 16'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule